// File: doc/BRIEF.md
# Paging Entry Protection Checker

This block judges one address-translation access against the directory entry and table entry that the page walk has fetched. It takes the mode controls (physical address extension, large-page extension, no-execute enable), the supported physical address width, both 64-bit entries, a large-page flag and the access kind (instruction fetch or data). From these it decides three things. The first is whether the entries mark the page as data-only. The second is whether any bit that must be zero is set in an entry that applies. The third is whether the access may proceed.

A request is qualified by a valid strobe. The verdict comes back registered one clock later, with a single-cycle response strobe. The page walk, translation caching and all permission bits other than execute-disable belong to neighbouring logic.

Top module: `pe_prot_check`

## Requirements
- R1: With extension mode on (`pae_en`=1) and `nxe_en`=1, for a small page (`large_pg`=0), bit 63 set in either the directory or the table entry makes the page data-only. A fetch to it returns `rsp_xfault`=1 and `rsp_allow`=0.
- R2: In the same mode, a small page whose directory and table entries both have bit 63 clear allows a fetch (`rsp_allow`=1, both fault flags 0).
- R3: For a large page (`large_pg`=1) in extension mode, only bit 63 of the directory entry decides data-only. Bit 63 of the table entry has no effect.
- R4: A data access (`is_fetch`=0) never raises `rsp_xfault`. A data access to a data-only page is allowed.
- R5: In extension mode with `pa_bits`=36, any of bits 39..36 set in an applicable entry raises `rsp_rsvd`=1 and `rsp_allow`=0. Bit 35 is not reserved.
- R6: In extension mode with `pa_bits`=32, bits 39..32 are reserved. Bits at or above 40 are never checked for address width, and with `pa_bits`=40 no address-width bit is reserved.
- R7: In extension mode with `nxe_en`=0, bit 63 of an applicable entry is reserved. Setting it raises `rsp_rsvd` and never `rsp_xfault`.
- R8: With `pae_en`=0 (whatever `pse_en` is), the upper 32 bits of both entries are ignored. Every access is allowed, with both fault flags 0.
- R9: When a reserved-bit fault and a data-only fetch coincide, `rsp_rsvd`=1 and `rsp_xfault`=0.
- R10: `rsp_valid` is 1 in the cycle after `req_valid` was sampled high and 0 otherwise. A synchronous active-high `rst` clears all four outputs.
- R11: For a large page, the table entry is not checked for reserved bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| pae_en | input | 1 | Physical address extension enable |
| pse_en | input | 1 | Large-page extension enable (non-extension modes) |
| nxe_en | input | 1 | No-execute enable |
| pa_bits | input | 6 | Supported physical address width in bits |
| pde | input | 64 | Directory entry |
| pte | input | 64 | Table entry (small pages) |
| large_pg | input | 1 | Access maps a large page |
| is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| rsp_valid | output | 1 | Response strobe |
| rsp_allow | output | 1 | Access allowed |
| rsp_xfault | output | 1 | Fetch to a data-only page |
| rsp_rsvd | output | 1 | Reserved bit set in an applicable entry |

## Verification
Every verdict is due exactly one clock edge after the request edge. The driver applies a request just after a falling edge and queues the expected flags. The monitor reads the outputs at the falling edge that follows the next rising edge, which is one full cycle later. Any response strobe with no queued item is a mismatch. Requests are also sent back to back, and the reset state is read before the first request.

// File: rtl/pe_pkg.sv
package pe_pkg;
    localparam int ENTRY_W = 64;
    localparam int XD_BIT  = 63;
    localparam int PAB_W   = 6;
    localparam int MIN_PA  = 32;

    typedef enum logic [1:0] {
        MODE_SMALL_ONLY = 2'd0,
        MODE_WIDE_LEGACY = 2'd1,
        MODE_EXT        = 2'd2
    } pg_mode_e;

    typedef struct packed {
        logic vld;
        logic allow;
        logic xfault;
        logic rsvd;
    } rsp_t;
endpackage

// File: rtl/pe_mode_decode.sv
module pe_mode_decode
    import pe_pkg::*;
(
    input  logic     pae_en,
    input  logic     pse_en,
    input  logic     nxe_en,
    output pg_mode_e mode,
    output logic     nx_active
);
    always_comb begin
        if (pae_en)      mode = MODE_EXT;
        else if (pse_en) mode = MODE_WIDE_LEGACY;
        else             mode = MODE_SMALL_ONLY;
        nx_active = pae_en & nxe_en;
    end
endmodule

// File: rtl/pe_rsvd_mask.sv
module pe_rsvd_mask
    import pe_pkg::*;
#(
    parameter int MAX_PA = 40
) (
    input  logic               ext_mode,
    input  logic               nxe_en,
    input  logic [PAB_W-1:0]   pa_bits,
    output logic [ENTRY_W-1:0] mask
);
    logic [PAB_W-1:0] pa_eff;

    always_comb begin
        pa_eff = (int'(pa_bits) < MIN_PA) ? PAB_W'(MIN_PA) : pa_bits;
    end

    for (genvar b = 0; b < ENTRY_W; b++) begin : g_bit
        if (b == XD_BIT) begin : g_xd
            assign mask[b] = ext_mode & ~nxe_en;
        end else if (b < MAX_PA) begin : g_pa
            assign mask[b] = ext_mode & (int'(pa_eff) <= b);
        end else begin : g_free
            assign mask[b] = 1'b0;
        end
    end
endmodule

// File: rtl/pe_xd_combine.sv
module pe_xd_combine (
    input  logic nx_active,
    input  logic large_pg,
    input  logic pde_xd,
    input  logic pte_xd,
    output logic data_only
);
    always_comb begin
        if (!nx_active)    data_only = 1'b0;
        else if (large_pg) data_only = pde_xd;
        else               data_only = pde_xd | pte_xd;
    end
endmodule

// File: rtl/pe_prot_check.sv
module pe_prot_check
    import pe_pkg::*;
#(
    parameter int MAX_PA = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               pae_en,
    input  logic               pse_en,
    input  logic               nxe_en,
    input  logic [PAB_W-1:0]   pa_bits,
    input  logic [ENTRY_W-1:0] pde,
    input  logic [ENTRY_W-1:0] pte,
    input  logic               large_pg,
    input  logic               is_fetch,
    output logic               rsp_valid,
    output logic               rsp_allow,
    output logic               rsp_xfault,
    output logic               rsp_rsvd
);
    pg_mode_e           mode;
    logic               nx_active;
    logic               ext_mode;
    logic [ENTRY_W-1:0] mask;
    logic               data_only;
    logic               rsvd_hit;
    rsp_t               rsp_d, rsp_q;

    pe_mode_decode u_mode (
        .pae_en    (pae_en),
        .pse_en    (pse_en),
        .nxe_en    (nxe_en),
        .mode      (mode),
        .nx_active (nx_active)
    );

    assign ext_mode = (mode == MODE_EXT);

    pe_rsvd_mask #(.MAX_PA(MAX_PA)) u_mask (
        .ext_mode (ext_mode),
        .nxe_en   (nxe_en),
        .pa_bits  (pa_bits),
        .mask     (mask)
    );

    pe_xd_combine u_xd (
        .nx_active (nx_active),
        .large_pg  (large_pg),
        .pde_xd    (pde[XD_BIT]),
        .pte_xd    (pte[XD_BIT]),
        .data_only (data_only)
    );

    always_comb begin
        rsvd_hit = (|(pde & mask)) | (~large_pg & (|(pte & mask)));
        rsp_d    = rsp_q;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            rsp_d.rsvd   = rsvd_hit;
            rsp_d.xfault = ~rsvd_hit & is_fetch & data_only;
            rsp_d.allow  = ~rsvd_hit & ~(is_fetch & data_only);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_allow  = rsp_q.allow;
    assign rsp_xfault = rsp_q.xfault;
    assign rsp_rsvd   = rsp_q.rsvd;

    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_rsvd_wins_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_rsvd |-> (!rsp_xfault && !rsp_allow));
    p_data_no_xfault_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_fetch) |=> !rsp_xfault);
    p_legacy_allow_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pae_en) |=> (rsp_allow && !rsp_xfault && !rsp_rsvd));
    p_nx_off_no_xfault_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !nxe_en) |=> !rsp_xfault);
endmodule

// File: tb/sim_pe_prot_check.sv
module sim_pe_prot_check;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  allow;
        logic  xf;
        logic  rs;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        pae_en = 1'b0, pse_en = 1'b0, nxe_en = 1'b0;
    logic [5:0]  pa_bits = 6'd36;
    logic [63:0] pde = '0, pte = '0;
    logic        large_pg = 1'b0, is_fetch = 1'b0;
    logic        rsp_valid, rsp_allow, rsp_xfault, rsp_rsvd;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_prot_check u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .pae_en(pae_en), .pse_en(pse_en), .nxe_en(nxe_en),
        .pa_bits(pa_bits), .pde(pde), .pte(pte),
        .large_pg(large_pg), .is_fetch(is_fetch),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_xfault(rsp_xfault), .rsp_rsvd(rsp_rsvd)
    );

    task automatic send(input logic pae, input logic pse, input logic nxe,
                        input logic [5:0] pab, input logic [63:0] d,
                        input logic [63:0] t, input logic lg, input logic f,
                        input logic ea, input logic ex, input logic er,
                        input string req);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; pae_en = pae; pse_en = pse; nxe_en = nxe;
        pa_bits = pab; pde = d; pte = t; large_pg = lg; is_fetch = f;
        e.allow = ea; e.xf = ex; e.rs = er; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: one response per queued item, read one full cycle after drive
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R10: response strobe with no request (got 1, expected 0)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if ({rsp_allow, rsp_xfault, rsp_rsvd} !== {e.allow, e.xf, e.rs}) begin
                    n_bad++;
                    $display("FAIL %s: allow/xfault/rsvd got %b%b%b expected %b%b%b",
                             e.req, rsp_allow, rsp_xfault, rsp_rsvd, e.allow, e.xf, e.rs);
                end
            end
        end
    end

    initial begin
        fork
            begin
                #(CLK_PERIOD * 5000);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish (got timeout, expected end)");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        n_chk++;
        if ({rsp_valid, rsp_allow, rsp_xfault, rsp_rsvd} !== 4'b0) begin
            n_bad++;
            $display("FAIL R10: reset outputs got %b expected 0000",
                     {rsp_valid, rsp_allow, rsp_xfault, rsp_rsvd});
        end
        rst = 1'b0;

        // extension mode, no-execute on, 36-bit width; back to back
        send(1,0,1,36, 64'h0, 64'h0, 0,1, 1,0,0, "R2");
        send(1,0,1,36, 64'h8000_0000_0000_0000, 64'h0, 0,1, 0,1,0, "R1");
        send(1,0,1,36, 64'h0, 64'h8000_0000_0000_0000, 0,1, 0,1,0, "R1");
        send(1,0,1,36, 64'h8000_0000_0000_0000, 64'h0, 0,0, 1,0,0, "R4");
        send(1,0,1,36, 64'h0, 64'h8000_0000_0000_0000, 1,1, 1,0,0, "R3");
        send(1,0,1,36, 64'h8000_0000_0000_0000, 64'h0, 1,1, 0,1,0, "R3");
        idle(2);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: idle strobe got %b expected 0", rsp_valid);
        end
        send(1,0,1,36, 64'h10_0000_0000, 64'h0, 0,0, 0,0,1, "R5");
        send(1,0,1,36, 64'h08_0000_0000, 64'h0, 0,0, 1,0,0, "R5");
        send(1,0,1,36, 64'h0, 64'h80_0000_0000, 0,0, 0,0,1, "R5");
        send(1,0,1,36, 64'h0, 64'h80_0000_0000, 1,0, 1,0,0, "R11");
        send(1,0,1,32, 64'h01_0000_0000, 64'h0, 0,0, 0,0,1, "R6");
        send(1,0,1,32, 64'h100_0000_0000, 64'h0, 0,0, 1,0,0, "R6");
        send(1,0,1,40, 64'h80_0000_0000, 64'h0, 0,0, 1,0,0, "R6");
        send(1,0,0,36, 64'h8000_0000_0000_0000, 64'h0, 0,1, 0,0,1, "R7");
        send(1,0,0,36, 64'h0, 64'h8000_0000_0000_0000, 0,0, 0,0,1, "R7");
        send(1,0,1,36, 64'h8000_0020_0000_0000, 64'h0, 0,1, 0,0,1, "R9");
        send(0,0,1,36, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 0,1, 1,0,0, "R8");
        send(0,1,1,32, 64'h8000_0000_0000_0000, 64'h0, 1,1, 1,0,0, "R8");
        idle(3);

        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R10: missing responses got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule